// File: doc/BRIEF.md
# Three-Floor Lift Sequencing Controller

This block steers one lift car over a small number of floors (three by default). It holds every hall call and cabin stop in its own latch until the call is served. It moves the car one floor for each pulse of a slow movement tick. At each stop it runs a fixed door sequence: one tick to open, four ticks fully open, one tick to close. It reports the car's floor, its direction of travel, whether the door is open, and one acknowledge bit for each request.

The buttons arrive already debounced. They are captured on cycles marked by a fast sampling enable. The state of the car changes only on cycles marked by the movement tick, and both enables share one clock. Calls are served collectively. While rising, the car stops for cabin stops and up calls in floor order. It passes floors that hold only down calls while anything is pending higher. When only down calls remain above, it climbs to the highest of them, turns round there and serves it. Descent mirrors this.

Top module: `lift_ctrl`

## Requirements
- R1: Raising `rst` at any time, with or without a clock edge, puts the car at floor 1 with `door_o`=1, `dir_o`=00 and all acknowledge bits 0. While no request is pending, the door stays open at floor 1.
- R2: An acknowledge bit goes to 1 after a cycle in which its button is 1 and `scan_en` is 1. It stays 1 until the call is served. A button seen only while `scan_en` is 0 is not recorded.
- R3: The up button of the top floor (`up_btn[NUM_FLOORS-1]`) and the down button of floor 1 (`dn_btn[0]`) have no effect. Their acknowledge bits stay 0.
- R4: Floor, door and direction change only at the end of a cycle with `step_en`=1. In a moving state each tick shifts `floor_o` by exactly one. The tick that selects a direction from rest leaves `floor_o` unchanged.
- R5: On the tick that brings the car to a floor it will serve, `door_o` stays 0. It is 1 for the next four ticks and returns to 0 on the fifth. `floor_o` does not change while `door_o` is 1.
- R6: While the door is opening, the latches for that floor's cabin stop and for its hall call in the current direction are cleared. A press of either during that tick is discarded. The clear wins over the set in the same cycle.
- R7: When rising, the car stops at cabin stops and up calls above it from the lowest to the highest. It passes a floor holding only a down call while any request lies higher.
- R8: When the only requests above the car are down calls, the car rises to the highest of them. It stops there with `dir_o`=10 and clears that down call.
- R9: When descending, the car stops at cabin stops and down calls below it from the highest to the lowest. It passes a floor holding only an up call while any request lies lower. It reverses at the lowest up call when only up calls remain below.
- R10: A request at the floor where the car stands with the door closed starts the door sequence on the next tick, without any movement.
- R11: `dir_o` keeps its value through the door sequence and through the first idle tick after it. After one idle tick with nothing pending, `dir_o` becomes 00 and the car stays where it is.
- R12: `floor_o` is the floor number in binary, from 1 to `NUM_FLOORS`. `dir_o` is 01 for up, 10 for down and 00 for idle. Bit i of every button and acknowledge vector belongs to floor i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both enables |
| rst | input | 1 | Asynchronous reset, active high |
| step_en | input | 1 | One-cycle movement tick (nominally once per second) |
| scan_en | input | 1 | Button sampling enable |
| cab_btn | input | NUM_FLOORS | Cabin stop buttons |
| up_btn | input | NUM_FLOORS | Hall up buttons (top bit unused) |
| dn_btn | input | NUM_FLOORS | Hall down buttons (bit 0 unused) |
| floor_o | output | $clog2(NUM_FLOORS+1) | Current floor, binary |
| dir_o | output | 2 | Direction indicator |
| door_o | output | 1 | Door-open indicator |
| cab_ack | output | NUM_FLOORS | Pending cabin stops |
| up_ack | output | NUM_FLOORS | Pending up calls |
| dn_ack | output | NUM_FLOORS | Pending down calls |

## Verification
A button press and the service clear of the same latch can land in the same cycle. This happens when a passenger presses a call at the floor where the door is opening. The bench provokes it by pressing the matching hall call during the opening tick, and in the same tick a cabin stop for another floor. It judges the result at the acknowledge pins. The matching call must stay 0, while the other floor's stop must latch and later pull the car up. A second overlap is a movement tick arriving while the car sits between its direction choice and its first floor change. The bench confirms that the floor holds over idle clocks and steps only on the tick.

// File: rtl/lift_pkg.sv
package lift_pkg;

  typedef enum logic [3:0] {
    ST_HOME,
    ST_IDLE,
    ST_RISE,
    ST_FALL,
    ST_OPEN,
    ST_HOLD1,
    ST_HOLD2,
    ST_HOLD3,
    ST_HOLD4,
    ST_SHUT
  } car_state_e;

  typedef enum logic [1:0] {
    HEAD_NONE = 2'b00,
    HEAD_UP   = 2'b01,
    HEAD_DOWN = 2'b10
  } heading_e;

endpackage

// File: rtl/lift_req_bank.sv
module lift_req_bank #(
  parameter int NUM_FLOORS = 3,
  parameter logic [NUM_FLOORS-1:0] LIVE = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scan_en,
  input  logic [NUM_FLOORS-1:0] btn_i,
  input  logic [NUM_FLOORS-1:0] clr_i,
  output logic [NUM_FLOORS-1:0] pend_o
);

  logic unused_bits;
  assign unused_bits = ^(btn_i & ~LIVE) ^ ^(clr_i & ~LIVE);

  for (genvar g = 0; g < NUM_FLOORS; g++) begin : g_slot
    if (LIVE[g]) begin : g_live
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          pend_o[g] <= 1'b0;
        end else if (clr_i[g]) begin
          pend_o[g] <= 1'b0;
        end else if (scan_en && btn_i[g]) begin
          pend_o[g] <= 1'b1;
        end
      end
    end else begin : g_dead
      assign pend_o[g] = 1'b0;
    end
  end

endmodule

// File: rtl/lift_call_scan.sv
module lift_call_scan #(
  parameter int NUM_FLOORS = 3,
  parameter int FW = $clog2(NUM_FLOORS + 1)
) (
  input  logic [FW-1:0]         floor_i,
  input  logic [NUM_FLOORS-1:0] cab_i,
  input  logic [NUM_FLOORS-1:0] up_i,
  input  logic [NUM_FLOORS-1:0] dn_i,
  output logic                  here_cab,
  output logic                  here_up,
  output logic                  here_dn,
  output logic                  above_any,
  output logic                  below_any
);

  always_comb begin
    here_cab  = 1'b0;
    here_up   = 1'b0;
    here_dn   = 1'b0;
    above_any = 1'b0;
    below_any = 1'b0;
    for (int i = 0; i < NUM_FLOORS; i++) begin
      logic [FW-1:0] num;
      logic          any;
      num = FW'(i + 1);
      any = cab_i[i] | up_i[i] | dn_i[i];
      if (num == floor_i) begin
        here_cab = cab_i[i];
        here_up  = up_i[i];
        here_dn  = dn_i[i];
      end else if (num > floor_i) begin
        above_any = above_any | any;
      end else begin
        below_any = below_any | any;
      end
    end
  end

endmodule

// File: rtl/lift_seq_fsm.sv
module lift_seq_fsm
  import lift_pkg::*;
#(
  parameter int NUM_FLOORS = 3,
  parameter int FW = $clog2(NUM_FLOORS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_en,
  input  logic                  any_pend,
  input  logic                  c_cab,
  input  logic                  c_up,
  input  logic                  c_dn,
  input  logic                  c_above,
  input  logic                  c_below,
  input  logic                  n_cab,
  input  logic                  n_up,
  input  logic                  n_dn,
  input  logic                  n_above,
  input  logic                  n_below,
  output logic [FW-1:0]         floor_o,
  output logic [FW-1:0]         peek_floor_o,
  output logic [1:0]            dir_o,
  output logic                  door_o,
  output logic [NUM_FLOORS-1:0] clr_cab_o,
  output logic [NUM_FLOORS-1:0] clr_up_o,
  output logic [NUM_FLOORS-1:0] clr_dn_o
);

  localparam logic [FW-1:0] FLOOR_ONE = FW'(1);

  car_state_e    state_q, state_d;
  heading_e      head_q, head_d;
  logic [FW-1:0] floor_q, floor_d;
  logic [NUM_FLOORS-1:0] here_1h;

  // Decide the next step from rest, keeping the current heading first.
  always_comb begin
    state_d = state_q;
    head_d  = head_q;
    floor_d = floor_q;
    unique case (state_q)
      ST_HOME: if (any_pend) state_d = ST_SHUT;
      ST_IDLE: begin
        unique case (head_q)
          HEAD_UP: begin
            if (c_cab || c_up)   begin state_d = ST_OPEN; head_d = HEAD_UP;   end
            else if (c_above)    begin state_d = ST_RISE; head_d = HEAD_UP;   end
            else if (c_dn)       begin state_d = ST_OPEN; head_d = HEAD_DOWN; end
            else if (c_below)    begin state_d = ST_FALL; head_d = HEAD_DOWN; end
            else                 head_d = HEAD_NONE;
          end
          HEAD_DOWN: begin
            if (c_cab || c_dn)   begin state_d = ST_OPEN; head_d = HEAD_DOWN; end
            else if (c_below)    begin state_d = ST_FALL; head_d = HEAD_DOWN; end
            else if (c_up)       begin state_d = ST_OPEN; head_d = HEAD_UP;   end
            else if (c_above)    begin state_d = ST_RISE; head_d = HEAD_UP;   end
            else                 head_d = HEAD_NONE;
          end
          default: begin
            if (c_up)            begin state_d = ST_OPEN; head_d = HEAD_UP;   end
            else if (c_dn)       begin state_d = ST_OPEN; head_d = HEAD_DOWN; end
            else if (c_cab)      state_d = ST_OPEN;
            else if (c_above)    begin state_d = ST_RISE; head_d = HEAD_UP;   end
            else if (c_below)    begin state_d = ST_FALL; head_d = HEAD_DOWN; end
            else                 head_d = HEAD_NONE;
          end
        endcase
      end
      ST_RISE: begin
        floor_d = peek_floor_o;
        if (n_cab || n_up)       state_d = ST_OPEN;
        else if (n_above)        state_d = ST_RISE;
        else if (n_dn)           begin state_d = ST_OPEN; head_d = HEAD_DOWN; end
        else                     state_d = ST_IDLE;
      end
      ST_FALL: begin
        floor_d = peek_floor_o;
        if (n_cab || n_dn)       state_d = ST_OPEN;
        else if (n_below)        state_d = ST_FALL;
        else if (n_up)           begin state_d = ST_OPEN; head_d = HEAD_UP; end
        else                     state_d = ST_IDLE;
      end
      ST_OPEN:  state_d = ST_HOLD1;
      ST_HOLD1: state_d = ST_HOLD2;
      ST_HOLD2: state_d = ST_HOLD3;
      ST_HOLD3: state_d = ST_HOLD4;
      ST_HOLD4: state_d = ST_SHUT;
      ST_SHUT:  state_d = ST_IDLE;
      default:  state_d = ST_HOME;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= ST_HOME;
      head_q  <= HEAD_NONE;
      floor_q <= FLOOR_ONE;
    end else if (step_en) begin
      state_q <= state_d;
      head_q  <= head_d;
      floor_q <= floor_d;
    end
  end

  assign here_1h      = NUM_FLOORS'(1) << (floor_q - FLOOR_ONE);
  assign peek_floor_o = (state_q == ST_FALL) ? floor_q - FLOOR_ONE : floor_q + FLOOR_ONE;
  assign floor_o      = floor_q;
  assign dir_o        = head_q;
  assign door_o       = (state_q == ST_HOME)  || (state_q == ST_HOLD1) ||
                        (state_q == ST_HOLD2) || (state_q == ST_HOLD3) ||
                        (state_q == ST_HOLD4);

  // Service strobes stay up for the whole opening tick.
  assign clr_cab_o = (state_q == ST_OPEN) ? here_1h : '0;
  assign clr_up_o  = (state_q == ST_OPEN && head_q == HEAD_UP)   ? here_1h : '0;
  assign clr_dn_o  = (state_q == ST_OPEN && head_q == HEAD_DOWN) ? here_1h : '0;

endmodule

// File: rtl/lift_ctrl.sv
module lift_ctrl #(
  parameter int NUM_FLOORS = 3,
  localparam int FW = $clog2(NUM_FLOORS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_en,
  input  logic                  scan_en,
  input  logic [NUM_FLOORS-1:0] cab_btn,
  input  logic [NUM_FLOORS-1:0] up_btn,
  input  logic [NUM_FLOORS-1:0] dn_btn,
  output logic [FW-1:0]         floor_o,
  output logic [1:0]            dir_o,
  output logic                  door_o,
  output logic [NUM_FLOORS-1:0] cab_ack,
  output logic [NUM_FLOORS-1:0] up_ack,
  output logic [NUM_FLOORS-1:0] dn_ack
);

  localparam logic [NUM_FLOORS-1:0] ALL_LIVE = '1;
  localparam logic [NUM_FLOORS-1:0] UP_LIVE  = ALL_LIVE >> 1;
  localparam logic [NUM_FLOORS-1:0] DN_LIVE  = ALL_LIVE << 1;

  logic [NUM_FLOORS-1:0] clr_cab, clr_up, clr_dn;
  logic [FW-1:0]         peek_floor;
  logic c_cab, c_up, c_dn, c_above, c_below;
  logic n_cab, n_up, n_dn, n_above, n_below;
  logic any_pend;

  lift_req_bank #(.NUM_FLOORS(NUM_FLOORS), .LIVE(ALL_LIVE)) u_cab_bank (
    .clk(clk), .rst(rst), .scan_en(scan_en), .btn_i(cab_btn), .clr_i(clr_cab), .pend_o(cab_ack)
  );
  lift_req_bank #(.NUM_FLOORS(NUM_FLOORS), .LIVE(UP_LIVE)) u_up_bank (
    .clk(clk), .rst(rst), .scan_en(scan_en), .btn_i(up_btn), .clr_i(clr_up), .pend_o(up_ack)
  );
  lift_req_bank #(.NUM_FLOORS(NUM_FLOORS), .LIVE(DN_LIVE)) u_dn_bank (
    .clk(clk), .rst(rst), .scan_en(scan_en), .btn_i(dn_btn), .clr_i(clr_dn), .pend_o(dn_ack)
  );

  assign any_pend = |{cab_ack, up_ack, dn_ack};

  lift_call_scan #(.NUM_FLOORS(NUM_FLOORS), .FW(FW)) u_scan_here (
    .floor_i(floor_o), .cab_i(cab_ack), .up_i(up_ack), .dn_i(dn_ack),
    .here_cab(c_cab), .here_up(c_up), .here_dn(c_dn),
    .above_any(c_above), .below_any(c_below)
  );

  lift_call_scan #(.NUM_FLOORS(NUM_FLOORS), .FW(FW)) u_scan_next (
    .floor_i(peek_floor), .cab_i(cab_ack), .up_i(up_ack), .dn_i(dn_ack),
    .here_cab(n_cab), .here_up(n_up), .here_dn(n_dn),
    .above_any(n_above), .below_any(n_below)
  );

  lift_seq_fsm #(.NUM_FLOORS(NUM_FLOORS), .FW(FW)) u_fsm (
    .clk(clk), .rst(rst), .step_en(step_en), .any_pend(any_pend),
    .c_cab(c_cab), .c_up(c_up), .c_dn(c_dn), .c_above(c_above), .c_below(c_below),
    .n_cab(n_cab), .n_up(n_up), .n_dn(n_dn), .n_above(n_above), .n_below(n_below),
    .floor_o(floor_o), .peek_floor_o(peek_floor), .dir_o(dir_o), .door_o(door_o),
    .clr_cab_o(clr_cab), .clr_up_o(clr_up), .clr_dn_o(clr_dn)
  );

endmodule

// File: rtl/lift_ctrl_chk.sv
module lift_ctrl_chk #(
  parameter int NUM_FLOORS = 3,
  localparam int FW = $clog2(NUM_FLOORS + 1)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  step_en,
  input logic                  scan_en,
  input logic [NUM_FLOORS-1:0] cab_btn,
  input logic [NUM_FLOORS-1:0] up_btn,
  input logic [NUM_FLOORS-1:0] dn_btn,
  input logic [FW-1:0]         floor_o,
  input logic [1:0]            dir_o,
  input logic                  door_o,
  input logic [NUM_FLOORS-1:0] cab_ack,
  input logic [NUM_FLOORS-1:0] up_ack,
  input logic [NUM_FLOORS-1:0] dn_ack
);

  localparam logic [FW-1:0] TOP = FW'(NUM_FLOORS);

  // R12
  floor_range_chk: assert property (@(posedge clk) disable iff (rst)
    (floor_o >= FW'(1)) && (floor_o <= TOP));

  // R12
  dir_code_chk: assert property (@(posedge clk) disable iff (rst)
    dir_o != 2'b11);

  // R4
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(floor_o));

  // R4
  door_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(door_o) && $stable(dir_o)));

  // R4
  floor_step_chk: assert property (@(posedge clk) disable iff (rst)
    step_en |=> (floor_o == $past(floor_o) || floor_o == $past(floor_o) + FW'(1) ||
                 floor_o == $past(floor_o) - FW'(1)));

  // R5
  door_still_chk: assert property (@(posedge clk) disable iff (rst)
    door_o |=> $stable(floor_o));

  // R2
  cab_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ((cab_ack & ~$past(cab_ack)) & ~$past(cab_btn & {NUM_FLOORS{scan_en}})) == '0);

  // R2
  hall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (((up_ack & ~$past(up_ack)) & ~$past(up_btn & {NUM_FLOORS{scan_en}})) |
     ((dn_ack & ~$past(dn_ack)) & ~$past(dn_btn & {NUM_FLOORS{scan_en}}))) == '0);

endmodule

bind lift_ctrl lift_ctrl_chk #(.NUM_FLOORS(NUM_FLOORS)) u_chk (
  .clk(clk), .rst(rst), .step_en(step_en), .scan_en(scan_en),
  .cab_btn(cab_btn), .up_btn(up_btn), .dn_btn(dn_btn),
  .floor_o(floor_o), .dir_o(dir_o), .door_o(door_o),
  .cab_ack(cab_ack), .up_ack(up_ack), .dn_ack(dn_ack)
);

// File: tb/lift_ctrl_tb.sv
`timescale 1ns/1ps
module lift_ctrl_tb;

  localparam int N = 3;
  localparam int FW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic scan_en = 1'b1;
  logic [N-1:0] cab_btn = '0, up_btn = '0, dn_btn = '0;
  logic [FW-1:0] floor_o;
  logic [1:0] dir_o;
  logic door_o;
  logic [N-1:0] cab_ack, up_ack, dn_ack;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;

  lift_ctrl #(.NUM_FLOORS(N)) u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .scan_en(scan_en),
    .cab_btn(cab_btn), .up_btn(up_btn), .dn_btn(dn_btn),
    .floor_o(floor_o), .dir_o(dir_o), .door_o(door_o),
    .cab_ack(cab_ack), .up_ack(up_ack), .dn_ack(dn_ack)
  );

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk) step_en = 1'b1;
    @(negedge clk) step_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // kind: 0 cabin, 1 up, 2 down
  task automatic press(input int kind, input int idx);
    @(negedge clk);
    case (kind)
      0: cab_btn[idx] = 1'b1;
      1: up_btn[idx] = 1'b1;
      default: dn_btn[idx] = 1'b1;
    endcase
    @(negedge clk);
    cab_btn = '0; up_btn = '0; dn_btn = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1", "floor after reset", floor_o, 1);
    expect_eq("R1", "door after reset", door_o, 1);
    expect_eq("R1", "dir after reset", dir_o, 0);
    expect_eq("R1", "acks after reset", {cab_ack, up_ack, dn_ack}, 0);
  endtask

  task automatic t_dead_buttons();
    press(1, N - 1);
    press(2, 0);
    expect_eq("R3", "top up ack", up_ack, 0);
    expect_eq("R3", "floor1 down ack", dn_ack, 0);
    tick();
    expect_eq("R1", "door held open when idle", door_o, 1);
    expect_eq("R11", "car stays at floor 1", floor_o, 1);
  endtask

  task automatic t_scan_gate();
    scan_en = 1'b0;
    press(0, 1);
    expect_eq("R2", "press ignored without scan_en", cab_ack, 0);
    scan_en = 1'b1;
  endtask

  task automatic t_first_trip();
    press(0, 1);
    expect_eq("R2", "cabin ack latched", cab_ack, 3'b010);
    tick();
    expect_eq("R1", "door closes before moving", door_o, 0);
    tick();
    tick();
    expect_eq("R12", "dir up code", dir_o, 1);
    expect_eq("R4", "choice tick keeps floor", floor_o, 1);
    tick();
    expect_eq("R4", "one floor per tick", floor_o, 2);
    expect_eq("R5", "door shut on arrival tick", door_o, 0);
    expect_eq("R6", "cabin ack cleared", cab_ack, 0);
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_eq("R5", "door open hold", door_o, 1);
      if (i == 1) expect_eq("R11", "dir held while door open", dir_o, 1);
    end
    tick();
    expect_eq("R5", "door shut after four", door_o, 0);
    tick();
    expect_eq("R11", "dir held first idle tick", dir_o, 1);
    tick();
    expect_eq("R11", "dir idle when nothing pending", dir_o, 0);
    expect_eq("R11", "car parked", floor_o, 2);
  endtask

  task automatic t_same_floor_and_clash();
    press(1, 1);
    expect_eq("R2", "up ack latched", up_ack, 3'b010);
    tick();
    expect_eq("R10", "no movement for local call", floor_o, 2);
    expect_eq("R10", "door opening tick", door_o, 0);
    expect_eq("R10", "dir takes call heading", dir_o, 1);
    expect_eq("R6", "local up call served", up_ack, 0);
    press(1, 1);
    press(0, 2);
    expect_eq("R6", "press during opening discarded", up_ack, 0);
    expect_eq("R2", "other floor press latched", cab_ack, 3'b100);
    tick();
    expect_eq("R10", "door opens on next tick", door_o, 1);
    ticks(5);
    tick();
    tick();
    expect_eq("R7", "reached floor 3", floor_o, 3);
    expect_eq("R6", "floor 3 stop cleared", cab_ack, 0);
    ticks(6);
  endtask

  task automatic t_descend();
    press(0, 0);
    press(1, 1);
    tick();
    expect_eq("R12", "dir down code", dir_o, 2);
    tick();
    expect_eq("R9", "passing floor 2", floor_o, 2);
    expect_eq("R9", "no stop for up call", door_o, 0);
    expect_eq("R9", "up call still pending", up_ack, 3'b010);
    tick();
    expect_eq("R9", "stop at floor 1", floor_o, 1);
    expect_eq("R9", "floor 1 stop cleared", cab_ack, 0);
    ticks(6);
    tick();
    expect_eq("R9", "reverse to reach up call", dir_o, 1);
    tick();
    expect_eq("R9", "up call floor reached", floor_o, 2);
    expect_eq("R6", "up call cleared", up_ack, 0);
    ticks(6);
  endtask

  task automatic t_overshoot();
    press(0, 0);
    tick();
    tick();
    expect_eq("R9", "back at floor 1", floor_o, 1);
    ticks(6);
    press(2, 1);
    press(2, 2);
    tick();
    expect_eq("R7", "heading up for calls above", dir_o, 1);
    repeat (10) @(negedge clk);
    expect_eq("R4", "no floor change between ticks", floor_o, 1);
    tick();
    expect_eq("R7", "passing floor 2", floor_o, 2);
    expect_eq("R7", "no stop for down call below others", door_o, 0);
    expect_eq("R7", "floor 2 down call kept", dn_ack, 3'b110);
    tick();
    expect_eq("R8", "reached highest down call", floor_o, 3);
    expect_eq("R8", "reversed on arrival", dir_o, 2);
    expect_eq("R8", "top down call cleared", dn_ack, 3'b010);
    ticks(6);
    tick();
    tick();
    expect_eq("R9", "down call at floor 2", floor_o, 2);
    expect_eq("R6", "floor 2 down call cleared", dn_ack, 0);
  endtask

  task automatic t_async_reset();
    ticks(2);
    press(0, 2);
    @(negedge clk);
    #3 rst = 1'b1;
    #1;
    expect_eq("R1", "async floor", floor_o, 1);
    expect_eq("R1", "async door", door_o, 1);
    expect_eq("R1", "async dir", dir_o, 0);
    expect_eq("R1", "async acks", cab_ack, 0);
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_dead_buttons();
    t_scan_gate();
    t_first_trip();
    t_same_floor_and_clash();
    t_descend();
    t_overshoot();
    t_async_reset();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule